// File: doc/BRIEF.md
# Interrupt Aggregator with Message Doorbell

This block gathers a bank of interrupt sources into one combined request line for a parent interrupt controller. Each source owns one pending bit in a cause bank and one disable bit in a mask bank. Both banks are split into 32-bit words on a small memory-mapped register bus. Source n lives in word n/32 at bit n%32. The low sources, 0 to 20, are level-high wires that latch their pending bit on every cycle they are asserted. The remaining sources, 21 to 63, are message interrupts. A device raises one by writing its source number to a doorbell word.

Software services the block by reading the cause words, lowest word first. It acknowledges a source by writing a one to its cause bit, and it gates sources through the mask words. The combined output is registered. It goes high one cycle after any pending bit whose mask bit is zero is present.

Top module: `irq_collector`

## Requirements
- R1: After reset both mask words read 0xFFFFFFFF, both cause words read 0x00000000 and `irq_out` is low.
- R2: Source n is held in cause word n/32 at bit n%32. Cause word k is read at byte offset 0x00 + 4*k.
- R3: A write to cause word k clears every pending bit whose data bit is 1. It leaves every bit whose data bit is 0 unchanged.
- R4: Mask word k sits at byte offset 0x20 + 4*k and reads back the last value written. A mask bit of 1 disables its source and a mask bit of 0 enables it.
- R5: A write to byte offset 0x30 sets the cause bit of the source whose number equals the written data. Data values of 64 or more change no cause bit.
- R6: While wired input i (0 to 20) is high, cause bit i is set on every cycle. A clear written while the input is still high leaves the bit set.
- R7: `irq_out` is high in the cycle after a cycle in which some cause bit is set with its mask bit 0. Otherwise it is low, so pending sources that are all masked keep it low.
- R8: Writing 0xFFFFFFFF to both cause words and both mask words, with the wired inputs low, leaves every cause bit clear, every source masked and `irq_out` low.
- R9: Read data is registered and is valid in the cycle after `bus_rd`. Reads of any other offset, including the doorbell, return 0. Writes to any other offset change no cause or mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wired_irq | input | 21 | Level-high wired sources 0 to 20 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The doorbell is driven with source numbers 21, 32 and 63. These fall at the split between the wired and message ranges and at both edges of the upper word, so they tell apart a wrong word index from a wrong bit index. Out-of-range doorbell values (64 and all ones) and writes to an unused offset separate "ignored" from "aliased into a low bit". A wired input is cleared once while still high and once after it falls, which distinguishes level re-latching from a missed clear. Masked and unmasked pending bits are combined with each cause word, checking that the output tracks only unmasked causes.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;
  // register layout (byte offsets)
  localparam int CAUSE_BASE   = 'h00;
  localparam int MASK_BASE    = 'h20;
  localparam int DOORBELL_OFF = 'h30;
  localparam int WORD_BYTES   = 4;
endpackage

// File: rtl/irq_collector_decode.sv
module irq_collector_decode
  import irq_collector_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] db_set,
  output logic [NUM_SRC/REG_W-1:0] mask_we
);
  localparam int NUM_REGS = NUM_SRC / REG_W;
  localparam int IDX_W    = $clog2(NUM_SRC);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    logic cause_hit;
    assign cause_hit  = bus_wr && (bus_addr == ADDR_W'(CAUSE_BASE + WORD_BYTES * k));
    assign mask_we[k] = bus_wr && (bus_addr == ADDR_W'(MASK_BASE + WORD_BYTES * k));
    assign clr_vec[k*REG_W +: REG_W] = cause_hit ? bus_wdata : '0;
  end

  logic db_hit;
  assign db_hit = bus_wr && (bus_addr == ADDR_W'(DOORBELL_OFF));

  always_comb begin
    db_set = '0;
    if (db_hit && (bus_wdata < REG_W'(NUM_SRC)))
      db_set[bus_wdata[IDX_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/irq_collector_bank.sv
module irq_collector_bank #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  input  logic             mask_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] cause_o,
  output logic [REG_W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_o <= '0;
      mask_o  <= '1;
    end else begin
      // a set in the same cycle as a clear wins
      cause_o <= (cause_o & ~clr_i) | set_i;
      if (mask_we_i)
        mask_o <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_collector_merge.sv
module irq_collector_merge #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] cause_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(cause_i & ~mask_i);
  end
endmodule

// File: rtl/irq_collector_readback.sv
module irq_collector_readback
  import irq_collector_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] cause_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [REG_W-1:0]   rdata_o
);
  localparam int NUM_REGS = NUM_SRC / REG_W;

  logic [REG_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (bus_addr == ADDR_W'(CAUSE_BASE + WORD_BYTES * k))
        rd_mux = cause_i[k*REG_W +: REG_W];
      if (bus_addr == ADDR_W'(MASK_BASE + WORD_BYTES * k))
        rd_mux = mask_i[k*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_o <= '0;
    else if (bus_rd) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NUM_SRC   = 64,
  parameter int REG_W     = 32,
  parameter int NUM_WIRED = 21,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WIRED-1:0] wired_irq,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic                 irq_out
);
  localparam int NUM_REGS = NUM_SRC / REG_W;

  logic [NUM_SRC-1:0]  cause_q;
  logic [NUM_SRC-1:0]  mask_q;
  logic [NUM_SRC-1:0]  clr_vec;
  logic [NUM_SRC-1:0]  db_set;
  logic [NUM_SRC-1:0]  set_vec;
  logic [NUM_REGS-1:0] mask_we;

  irq_collector_decode #(
    .NUM_SRC(NUM_SRC), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .clr_vec(clr_vec), .db_set(db_set), .mask_we(mask_we)
  );

  // wired levels are zero-extended into the full source space
  assign set_vec = NUM_SRC'(wired_irq) | db_set;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    irq_collector_bank #(.REG_W(REG_W)) u_bank (
      .clk(clk), .rst(rst),
      .set_i(set_vec[g*REG_W +: REG_W]),
      .clr_i(clr_vec[g*REG_W +: REG_W]),
      .mask_we_i(mask_we[g]),
      .wdata_i(bus_wdata),
      .cause_o(cause_q[g*REG_W +: REG_W]),
      .mask_o(mask_q[g*REG_W +: REG_W])
    );
  end

  irq_collector_merge #(.NUM_SRC(NUM_SRC)) u_merge (
    .clk(clk), .rst(rst), .cause_i(cause_q), .mask_i(mask_q), .irq_o(irq_out)
  );

  irq_collector_readback #(
    .NUM_SRC(NUM_SRC), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) u_readback (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .cause_i(cause_q), .mask_i(mask_q), .rdata_o(bus_rdata)
  );
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk
  import irq_collector_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int REG_W     = 32,
  parameter int NUM_WIRED = 21,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_WIRED-1:0] wired_irq,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [REG_W-1:0]     bus_wdata,
  input logic [NUM_SRC-1:0]   cause_q,
  input logic [NUM_SRC-1:0]   mask_q,
  input logic                 irq_out
);
  localparam int NUM_REGS = NUM_SRC / REG_W;
  localparam int IDX_W    = $clog2(NUM_SRC);

  logic cause_wr, mask_wr, db_wr, live;
  assign cause_wr = bus_wr && (bus_addr >= ADDR_W'(CAUSE_BASE)) &&
                    (bus_addr < ADDR_W'(CAUSE_BASE + WORD_BYTES * NUM_REGS));
  assign mask_wr  = bus_wr && (bus_addr >= ADDR_W'(MASK_BASE)) &&
                    (bus_addr < ADDR_W'(MASK_BASE + WORD_BYTES * NUM_REGS));
  assign db_wr    = bus_wr && (bus_addr == ADDR_W'(DOORBELL_OFF)) &&
                    (bus_wdata < REG_W'(NUM_SRC));
  assign live     = |(cause_q & ~mask_q);

  // R3
  no_stray_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !cause_wr |=> (($past(cause_q) & ~cause_q) == '0));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> $stable(mask_q));

  // R5
  doorbell_set_chk: assert property (@(posedge clk) disable iff (rst)
    db_wr |=> cause_q[$past(bus_wdata[IDX_W-1:0])]);

  // R6
  wired_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (|wired_irq) |=> ((cause_q[NUM_WIRED-1:0] & $past(wired_irq)) == $past(wired_irq)));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    live |=> irq_out);

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !live |=> !irq_out);
endmodule

bind irq_collector irq_collector_chk #(
  .NUM_SRC(NUM_SRC), .REG_W(REG_W), .NUM_WIRED(NUM_WIRED), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wired_irq(wired_irq), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cause_q(cause_q),
  .mask_q(mask_q), .irq_out(irq_out)
);

// File: tb/irq_collector_bench.sv
`timescale 1ns/1ps
module irq_collector_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [20:0] wired_irq = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_collector u_irq_collector (
    .clk(clk), .rst(rst), .wired_irq(wired_irq), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    rd_check("R1 mask0", 8'h20, 32'hFFFF_FFFF);
    rd_check("R1 mask1", 8'h24, 32'hFFFF_FFFF);
    rd_check("R1 cause0", 8'h00, 32'h0);
    rd_check("R1 cause1", 8'h04, 32'h0);
    check("R1 irq_out", 32'(irq_out), 32'h0);
  endtask

  task automatic t_doorbell();
    wr(8'h30, 32'd21);
    rd_check("R5 R2 source 21", 8'h00, 32'h0020_0000);
    wr(8'h30, 32'd63);
    wr(8'h30, 32'd32);
    rd_check("R2 sources 32 and 63", 8'h04, 32'h8000_0001);
    check("R7 masked pending keeps irq low", 32'(irq_out), 32'h0);
    wr(8'h30, 32'd64);
    wr(8'h30, 32'hFFFF_FFFF);
    rd_check("R5 value 64+ ignored word0", 8'h00, 32'h0020_0000);
    rd_check("R5 value 64+ ignored word1", 8'h04, 32'h8000_0001);
  endtask

  task automatic t_mask();
    wr(8'h24, 32'h7FFF_FFFF);
    rd_check("R4 mask1 readback", 8'h24, 32'h7FFF_FFFF);
    check("R7 unmasked source 63 raises irq", 32'(irq_out), 32'h1);
    wr(8'h24, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R4 remask drops irq", 32'(irq_out), 32'h0);
  endtask

  task automatic t_w1c();
    wr(8'h04, 32'h0000_0001);
    rd_check("R3 clear bit0 keeps bit31", 8'h04, 32'h8000_0000);
    wr(8'h00, 32'h0);
    rd_check("R3 zero write leaves cause0", 8'h00, 32'h0020_0000);
  endtask

  task automatic t_wired();
    wired_irq[5] = 1'b1;
    @(negedge clk);
    rd_check("R6 wired level sets bit5", 8'h00, 32'h0020_0020);
    wr(8'h00, 32'h0000_0020);
    rd_check("R6 clear while high re-sets", 8'h00, 32'h0020_0020);
    wired_irq[5] = 1'b0;
    wr(8'h00, 32'h0000_0020);
    rd_check("R6 clear after drop", 8'h00, 32'h0020_0000);
    check("R7 idle irq", 32'(irq_out), 32'h0);
    wr(8'h20, 32'hFFFF_FFDF);
    wired_irq[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 unmasked wired raises irq", 32'(irq_out), 32'h1);
    wired_irq[5] = 1'b0;
  endtask

  task automatic t_unmapped();
    wr(8'h10, 32'hFFFF_FFFF);
    rd_check("R9 doorbell reads zero", 8'h30, 32'h0);
    rd_check("R9 unused offset reads zero", 8'h10, 32'h0);
    rd_check("R9 unused write keeps cause0", 8'h00, 32'h0020_0020);
    rd_check("R9 unused write keeps mask0", 8'h20, 32'hFFFF_FFDF);
  endtask

  task automatic t_all_ones();
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    rd_check("R8 cause0 cleared", 8'h00, 32'h0);
    rd_check("R8 cause1 cleared", 8'h04, 32'h0);
    rd_check("R8 mask0 all set", 8'h20, 32'hFFFF_FFFF);
    rd_check("R8 mask1 all set", 8'h24, 32'hFFFF_FFFF);
    check("R8 irq low", 32'(irq_out), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_doorbell();
    t_mask();
    t_w1c();
    t_wired();
    t_unmapped();
    t_all_ones();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule